// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block sits between a requester that wants to read or write a PHY register and a two-wire management master that can only move 16-bit switch registers. Each accepted request carries a PHY number, a page, a register index, a direction flag, a 16-bit payload and a flag that marks the MII-facing path. The block first checks the arguments. It then runs a short chain of dependent switch-register transactions and returns one response carrying an error flag and, for reads, the PHY register value.

Transactions to the master go out one at a time through a start/busy/done/error handshake. The block asserts a start pulse only when the master is not busy. It waits for done before it moves to the next step. A request is accepted only when no other sequence is running, so the register transactions of two accesses never interleave.

Top module: `phy_ind_seq`

## Requirements
- R1: A request whose PHY number exceeds 4, whose effective page exceeds 7 or whose register index exceeds 31 gets a response with `rspErr`=1 and causes no bus transaction.
- R2: The first transaction of every access is a write to switch register 0x8028 with data 1 when a PHY read follows and data 0 when a PHY write follows.
- R3: The second transaction is a write to the composed address. The composed address has bit 15 set, a single bit at position 9+PHY number, the page in bits 7:5 and the register index in bits 4:0.
- R4: The data of the second transaction is 0 for a PHY read and the request payload for a PHY write.
- R5: A PHY read ends with a read of switch register 0x8029. The value it returns appears on `rspData`, with `rspErr`=0.
- R6: When the master reports an error on any transaction of the main access, no further transaction starts and the response carries `rspErr`=1.
- R7: When `reqMii`=1 the page is taken as 0 whatever `reqPage` holds. It takes no part in the range check.
- R8: An MII-path write is followed by a complete read sequence of the same register. The response then has `rspData`=0 and `rspErr`=0. A failure during that read-back ends it early but is not reported.
- R9: `busStart` is asserted only while `busBusy` is low. At most one bus transaction is outstanding at any time.
- R10: `reqReady` is low from acceptance until the response. `rspValid` is a single-cycle pulse for each accepted request. A write response has `rspData`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request taken on this cycle when valid |
| reqPhy | input | 5 | PHY number |
| reqPage | input | 4 | Page number |
| reqReg | input | 6 | PHY register index |
| reqWrite | input | 1 | 1 = PHY write, 0 = PHY read |
| reqMii | input | 1 | MII-facing path: page forced to 0, write followed by read-back |
| reqWdata | input | 16 | Write payload |
| rspValid | output | 1 | One-cycle response strobe |
| rspErr | output | 1 | Range or bus error |
| rspData | output | 16 | PHY register value for reads, 0 otherwise |
| busStart | output | 1 | Start one switch-register transaction |
| busWrite | output | 1 | 1 = register write, 0 = register read |
| busAddr | output | 16 | Switch register address |
| busWdata | output | 16 | Switch register write data |
| busBusy | input | 1 | Master busy |
| busDone | input | 1 | Transaction complete |
| busErr | input | 1 | Transaction failed, valid with busDone |
| busRdata | input | 16 | Read data, valid with busDone |

## Verification
The bench probes each range limit on both sides: PHY 4 against PHY 5, page 7 against page 8, and register 31 against 32. A design with an off-by-one comparison would either reject a legal boundary request or put bus traffic on the wire for an illegal one. It injects master errors at the second step of a read and in the middle of an MII read-back. A design that did not stop would issue further starts, and one that reported the read-back failure would raise an error on a write that succeeded. It also holds the master busy before the first step to catch a start issued into a busy master. Finally it passes a nonzero page on the MII path to catch a page that leaks into the composed address.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } seqState_t;

  typedef struct packed {
    logic       load;
    logic       issue;
    logic       capture;
    logic       clearData;
    logic [1:0] stepIdx;
    logic       curRd;
  } seqCtl_t;
endpackage

// File: rtl/phy_seq_dp.sv
module phy_seq_dp
  import phy_seq_pkg::*;
#(
  parameter int PHY_W      = 5,
  parameter int PAGE_W     = 4,
  parameter int REG_W      = 6,
  parameter int MAX_PHY    = 4,
  parameter int MAX_PAGE   = 7,
  parameter int MAX_REG    = 31,
  parameter int PHY_SHIFT  = 9,
  parameter int PAGE_SHIFT = 5,
  parameter logic [WORD_W-1:0] CTRL_REG = 16'h8028,
  parameter logic [WORD_W-1:0] DATA_REG = 16'h8029
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [PHY_W-1:0]  reqPhy,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [REG_W-1:0]  reqReg,
  input  logic              reqWrite,
  input  logic              reqMii,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic [WORD_W-1:0] busRdata,
  output logic [WORD_W-1:0] busAddr,
  output logic [WORD_W-1:0] busWdata,
  output logic              busWrite,
  output logic              rangeOk,
  output logic              isWrite,
  output logic              isMii,
  output logic [WORD_W-1:0] rspData
);
  localparam int PAGE_FLD = $clog2(MAX_PAGE + 1);
  localparam int REG_FLD  = $clog2(MAX_REG + 1);

  logic [PHY_W-1:0]  phyQ;
  logic [PAGE_W-1:0] pageQ;
  logic [REG_W-1:0]  regQ;
  logic              wrQ;
  logic              miiQ;
  logic [WORD_W-1:0] wdQ;
  logic [WORD_W-1:0] rdQ;
  logic [PAGE_W-1:0] effPage;
  logic [WORD_W-1:0] indAddr;
  logic [MAX_PHY:0]  phySel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyQ  <= '0;
      pageQ <= '0;
      regQ  <= '0;
      wrQ   <= 1'b0;
      miiQ  <= 1'b0;
      wdQ   <= '0;
      rdQ   <= '0;
    end else begin
      if (ctl.load) begin
        phyQ  <= reqPhy;
        pageQ <= reqPage;
        regQ  <= reqReg;
        wrQ   <= reqWrite;
        miiQ  <= reqMii;
        wdQ   <= reqWdata;
      end
      if (ctl.clearData) rdQ <= '0;
      else if (ctl.capture) rdQ <= busRdata;
    end
  end

  assign effPage = miiQ ? '0 : pageQ;
  assign rangeOk = (int'(phyQ) <= MAX_PHY) && (int'(effPage) <= MAX_PAGE)
                && (int'(regQ) <= MAX_REG);
  assign isWrite = wrQ;
  assign isMii   = miiQ;
  assign rspData = rdQ;

  for (genvar p = 0; p <= MAX_PHY; p++) begin : g_phySel
    assign phySel[p] = (int'(phyQ) == p);
  end

  always_comb begin
    indAddr = '0;
    indAddr[WORD_W-1] = 1'b1;
    indAddr[PHY_SHIFT +: MAX_PHY + 1] = phySel;
    indAddr[PAGE_SHIFT +: PAGE_FLD] = effPage[PAGE_FLD-1:0];
    indAddr[REG_FLD-1:0] = regQ[REG_FLD-1:0];
  end

  always_comb begin
    busAddr  = CTRL_REG;
    busWdata = {{(WORD_W-1){1'b0}}, ctl.curRd};
    busWrite = 1'b1;
    case (ctl.stepIdx)
      2'd1: begin
        busAddr  = indAddr;
        busWdata = ctl.curRd ? '0 : wdQ;
      end
      2'd2: begin
        busAddr  = DATA_REG;
        busWdata = '0;
        busWrite = 1'b0;
      end
      default: ;
    endcase
  end

  // R3: composed address carries bit 15 and exactly one PHY-select bit
  a_r3_addr_shape: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issue && ctl.stepIdx == 2'd1) |->
      (busAddr[WORD_W-1] && $countones(busAddr[PHY_SHIFT +: MAX_PHY + 1]) == 1));

  // R10: response data of a write access stays cleared
  a_r10_wr_data_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issue && wrQ && !ctl.curRd) |-> (rdQ == '0));
endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  input  logic    rangeOk,
  input  logic    isWrite,
  input  logic    isMii,
  input  logic    busBusy,
  input  logic    busDone,
  input  logic    busErr,
  output seqCtl_t ctl,
  output logic    rspValid,
  output logic    rspErr
);
  seqState_t  state;
  logic [1:0] stepQ;
  logic       curRdQ;
  logic       verifyQ;
  logic       errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepQ   <= 2'd0;
      curRdQ  <= 1'b0;
      verifyQ <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) state <= ST_EVAL;
        ST_EVAL: begin
          stepQ   <= 2'd0;
          verifyQ <= 1'b0;
          curRdQ  <= !isWrite;
          errQ    <= !rangeOk;
          state   <= rangeOk ? ST_ISSUE : ST_RESP;
        end
        ST_ISSUE: if (!busBusy) state <= ST_WAIT;
        ST_WAIT: if (busDone) begin
          if (busErr) begin
            errQ  <= !verifyQ;
            state <= ST_RESP;
          end else if (stepQ == 2'd2) begin
            state <= ST_RESP;
          end else if (stepQ == 2'd1 && !curRdQ) begin
            if (isMii) begin
              verifyQ <= 1'b1;
              curRdQ  <= 1'b1;
              stepQ   <= 2'd0;
              state   <= ST_ISSUE;
            end else begin
              state <= ST_RESP;
            end
          end else begin
            stepQ <= stepQ + 2'd1;
            state <= ST_ISSUE;
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load      = (state == ST_IDLE) && reqValid;
    ctl.clearData = ctl.load;
    ctl.issue     = (state == ST_ISSUE) && !busBusy;
    ctl.capture   = (state == ST_WAIT) && busDone && !busErr
                  && (stepQ == 2'd2) && !verifyQ;
    ctl.stepIdx   = stepQ;
    ctl.curRd     = curRdQ;
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);
  assign rspErr   = errQ;

  // R9: a start is never followed directly by a second start
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |=> !ctl.issue);

  // R9: no start while a request may still be accepted
  a_r9_start_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |-> !reqReady);

  // R10: response is a single-cycle pulse followed by readiness
  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  // R1: an out-of-range request is answered with an error next
  a_r1_reject: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EVAL && !rangeOk) |=> (rspValid && rspErr));

  // R6: a failed main-access step ends the sequence with an error
  a_r6_err_ends: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && busDone && busErr && !verifyQ) |=> (rspValid && rspErr));

  // R8: a failed read-back is not reported
  a_r8_verify_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && busDone && busErr && verifyQ) |=> (rspValid && !rspErr));
endmodule

// File: rtl/phy_ind_seq.sv
module phy_ind_seq
  import phy_seq_pkg::*;
#(
  parameter int PHY_W    = 5,
  parameter int PAGE_W   = 4,
  parameter int REG_W    = 6,
  parameter int MAX_PHY  = 4,
  parameter int MAX_PAGE = 7,
  parameter int MAX_REG  = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [PHY_W-1:0]  reqPhy,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [REG_W-1:0]  reqReg,
  input  logic              reqWrite,
  input  logic              reqMii,
  input  logic [15:0]       reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [15:0]       rspData,
  output logic              busStart,
  output logic              busWrite,
  output logic [15:0]       busAddr,
  output logic [15:0]       busWdata,
  input  logic              busBusy,
  input  logic              busDone,
  input  logic              busErr,
  input  logic [15:0]       busRdata
);
  seqCtl_t ctl;
  logic    rangeOk;
  logic    isWrite;
  logic    isMii;

  phy_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rangeOk  (rangeOk),
    .isWrite  (isWrite),
    .isMii    (isMii),
    .busBusy  (busBusy),
    .busDone  (busDone),
    .busErr   (busErr),
    .ctl      (ctl),
    .rspValid (rspValid),
    .rspErr   (rspErr)
  );

  phy_seq_dp #(
    .PHY_W    (PHY_W),
    .PAGE_W   (PAGE_W),
    .REG_W    (REG_W),
    .MAX_PHY  (MAX_PHY),
    .MAX_PAGE (MAX_PAGE),
    .MAX_REG  (MAX_REG)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqPhy   (reqPhy),
    .reqPage  (reqPage),
    .reqReg   (reqReg),
    .reqWrite (reqWrite),
    .reqMii   (reqMii),
    .reqWdata (reqWdata),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busWrite (busWrite),
    .rangeOk  (rangeOk),
    .isWrite  (isWrite),
    .isMii    (isMii),
    .rspData  (rspData)
  );

  assign busStart = ctl.issue;

  // R9: never start into a busy master
  a_r9_no_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    busStart |-> !busBusy);
endmodule

// File: tb/sim_phy_ind_seq.sv
module sim_phy_ind_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [4:0] reqPhy = '0;
  logic [3:0] reqPage = '0;
  logic [5:0] reqReg = '0;
  logic reqWrite = 1'b0;
  logic reqMii = 1'b0;
  logic [15:0] reqWdata = '0;
  logic rspValid, rspErr;
  logic [15:0] rspData;
  logic busStart, busWrite;
  logic [15:0] busAddr, busWdata;
  logic busBusy;
  logic busDone = 1'b0;
  logic busErr = 1'b0;
  logic [15:0] busRdata = '0;

  int checks = 0;
  int fails = 0;
  int pend = 0;
  int txCnt = 0;
  int curIdx = 0;
  int errAt = -1;
  logic extBusy = 1'b0;
  logic [15:0] rdVal = 16'h0000;
  logic [15:0] logA [0:63];
  logic        logW [0:63];
  logic [15:0] logD [0:63];
  bit finished = 0;

  always #4 clk = ~clk;

  phy_ind_seq u0 (.*);

  assign busBusy = (pend > 0) || extBusy;

  always @(posedge clk) begin
    busDone <= 1'b0;
    busErr  <= 1'b0;
    if (!rstN) begin
      pend  <= 0;
      txCnt <= 0;
    end else if (busStart) begin
      logA[txCnt & 63] <= busAddr;
      logW[txCnt & 63] <= busWrite;
      logD[txCnt & 63] <= busWdata;
      curIdx <= txCnt;
      txCnt  <= txCnt + 1;
      pend   <= 3;
    end else if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        busDone  <= 1'b1;
        busErr   <= (curIdx == errAt);
        busRdata <= rdVal;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expAddr(int phy, int page, int rg);
    return 16'h8000 | (16'h1 << (phy + 9)) | 16'(page << 5) | 16'(rg);
  endfunction

  task automatic chkTx(string req, int idx, logic wr, logic [15:0] a, logic [15:0] d);
    chk({req, " write flag"}, 32'(logW[idx & 63]), 32'(wr));
    chk({req, " address"}, 32'(logA[idx & 63]), 32'(a));
    if (wr) chk({req, " data"}, 32'(logD[idx & 63]), 32'(d));
  endtask

  // Issues one request and waits for its response.
  task automatic doReq(int phy, int page, int rg, logic wr, logic mii,
                       logic [15:0] wd, int errRel,
                       output logic err, output logic [15:0] data, output int base);
    bit readyLeak;
    bit got;
    readyLeak = 0;
    got = 0;
    @(negedge clk);
    base  = txCnt;
    errAt = (errRel < 0) ? -1 : base + errRel;
    reqPhy = 5'(phy); reqPage = 4'(page); reqReg = 6'(rg);
    reqWrite = wr; reqMii = mii; reqWdata = wd; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 400 && !got; i++) begin
      if (rspValid) begin
        got = 1;
        err = rspErr;
        data = rspData;
      end else begin
        if (reqReady) readyLeak = 1;
        @(negedge clk);
      end
    end
    chk("R10 response seen", 32'(got), 32'd1);
    chk("R10 ready low while busy", 32'(readyLeak), 32'd0);
    @(negedge clk);
    chk("R10 single-cycle response", 32'(rspValid), 32'd0);
  endtask

  task automatic tReset();
    chk("R10 reset ready", 32'(reqReady), 32'd1);
    chk("R10 reset no response", 32'(rspValid), 32'd0);
    chk("R9 reset no start", 32'(busStart), 32'd0);
  endtask

  task automatic tRead();
    logic e; logic [15:0] d; int b;
    rdVal = 16'hBEEF;
    doReq(2, 3, 17, 1'b0, 1'b0, 16'h7777, -1, e, d, b);
    chk("R5 read count", 32'(txCnt - b), 32'd3);
    chkTx("R2 read ctrl", b, 1'b1, 16'h8028, 16'h0001);
    chkTx("R3 R4 read addr", b + 1, 1'b1, expAddr(2, 3, 17), 16'h0000);
    chkTx("R5 data reg", b + 2, 1'b0, 16'h8029, 16'h0000);
    chk("R5 read data", 32'(d), 32'h0000BEEF);
    chk("R5 read err", 32'(e), 32'd0);
  endtask

  task automatic tWrite();
    logic e; logic [15:0] d; int b;
    doReq(0, 7, 31, 1'b1, 1'b0, 16'h1234, -1, e, d, b);
    chk("R4 write count", 32'(txCnt - b), 32'd2);
    chkTx("R2 write ctrl", b, 1'b1, 16'h8028, 16'h0000);
    chkTx("R3 R4 write addr", b + 1, 1'b1, expAddr(0, 7, 31), 16'h1234);
    chk("R10 write data zero", 32'(d), 32'd0);
    chk("R4 write err", 32'(e), 32'd0);
  endtask

  task automatic tRange();
    logic e; logic [15:0] d; int b;
    doReq(5, 0, 0, 1'b0, 1'b0, 16'h0, -1, e, d, b);
    chk("R1 phy 5 err", 32'(e), 32'd1);
    chk("R1 phy 5 no traffic", 32'(txCnt - b), 32'd0);
    doReq(0, 8, 0, 1'b1, 1'b0, 16'h55, -1, e, d, b);
    chk("R1 page 8 err", 32'(e), 32'd1);
    chk("R1 page 8 no traffic", 32'(txCnt - b), 32'd0);
    doReq(1, 0, 32, 1'b0, 1'b0, 16'h0, -1, e, d, b);
    chk("R1 reg 32 err", 32'(e), 32'd1);
    chk("R1 reg 32 no traffic", 32'(txCnt - b), 32'd0);
    rdVal = 16'h0F0F;
    doReq(4, 0, 0, 1'b0, 1'b0, 16'h0, -1, e, d, b);
    chk("R1 phy 4 accepted", 32'(e), 32'd0);
    chk("R3 phy 4 addr", 32'(logA[(b + 1) & 63]), 32'(expAddr(4, 0, 0)));
  endtask

  task automatic tMiiWrite();
    logic e; logic [15:0] d; int b;
    rdVal = 16'hCAFE;
    doReq(1, 6, 5, 1'b1, 1'b1, 16'hA5A5, -1, e, d, b);
    chk("R8 mii write count", 32'(txCnt - b), 32'd5);
    chkTx("R7 R8 mii ctrl", b, 1'b1, 16'h8028, 16'h0000);
    chkTx("R7 mii addr page0", b + 1, 1'b1, expAddr(1, 0, 5), 16'hA5A5);
    chkTx("R8 verify ctrl", b + 2, 1'b1, 16'h8028, 16'h0001);
    chkTx("R8 verify addr", b + 3, 1'b1, expAddr(1, 0, 5), 16'h0000);
    chkTx("R8 verify data reg", b + 4, 1'b0, 16'h8029, 16'h0000);
    chk("R8 data discarded", 32'(d), 32'd0);
    chk("R8 err", 32'(e), 32'd0);
  endtask

  task automatic tMiiRead();
    logic e; logic [15:0] d; int b;
    rdVal = 16'h1357;
    doReq(3, 15, 9, 1'b0, 1'b1, 16'h0, -1, e, d, b);
    chk("R7 mii page ignored err", 32'(e), 32'd0);
    chk("R7 mii read addr", 32'(logA[(b + 1) & 63]), 32'(expAddr(3, 0, 9)));
    chk("R5 mii read data", 32'(d), 32'h00001357);
  endtask

  task automatic tErrors();
    logic e; logic [15:0] d; int b;
    doReq(2, 1, 4, 1'b0, 1'b0, 16'h0, 1, e, d, b);
    chk("R6 error reported", 32'(e), 32'd1);
    chk("R6 stop after fail", 32'(txCnt - b), 32'd2);
    doReq(0, 0, 1, 1'b1, 1'b1, 16'h4242, 3, e, d, b);
    chk("R8 verify fail quiet", 32'(e), 32'd0);
    chk("R8 verify fail stops", 32'(txCnt - b), 32'd4);
    doReq(0, 0, 1, 1'b1, 1'b1, 16'h4242, 0, e, d, b);
    chk("R6 mii write fail err", 32'(e), 32'd1);
    chk("R6 mii write fail stops", 32'(txCnt - b), 32'd1);
  endtask

  task automatic tBusyHold();
    logic e; logic [15:0] d; int b;
    bit early;
    early = 0;
    @(negedge clk);
    b = txCnt;
    extBusy = 1'b1;
    reqPhy = 5'd1; reqPage = 4'd2; reqReg = 6'd3;
    reqWrite = 1'b0; reqMii = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (busStart) early = 1;
      @(negedge clk);
    end
    chk("R9 no start while busy", 32'(early), 32'd0);
    chk("R9 no traffic while busy", 32'(txCnt - b), 32'd0);
    extBusy = 1'b0;
    for (int i = 0; i < 100 && !rspValid; i++) @(negedge clk);
    chk("R9 completes after release", 32'(txCnt - b), 32'd3);
    @(negedge clk);
    doReq(1, 2, 3, 1'b0, 1'b0, 16'h0, -1, e, d, b);
    chk("R9 next access clean", 32'(e), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRead();
    tWrite();
    tRange();
    tMiiWrite();
    tMiiRead();
    tErrors();
    tBusyHold();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule